// File: doc/BRIEF.md
# Mixed-Width Instruction Length and Flow Decoder

This block examines the instruction at the fetch point of a processor whose instruction set freely mixes 16-bit and 32-bit encodings, optionally followed by a 32-bit long-immediate word. It receives the first two 16-bit parcels, the word that may hold a long immediate, and the current PC. It returns the total instruction length in bytes and a classification of control flow: whether the instruction can redirect the PC, whether it is a jump or a call, whether the target is direct or held in a register, and whether it has a delay slot. It also returns the target address for direct transfers. For register-indirect transfers it returns the register index, because the block has no register file access.

A fetch unit or a debug/single-step engine uses it to compute the fall-through PC (`pc + lenBytes`) and the taken target in one step. The decode itself is purely combinational. The parameter `OUT_REG` chooses between combinational outputs and outputs held in one register stage.

Top module: `vlen_decode`

## Requirements
- R1: The major opcode is `firstParcel[15:11]`. A value below 11 marks a 32-bit instruction with a base length of 4 bytes; any other value marks a 16-bit instruction with a base length of 2 bytes.
- R2: For a 32-bit instruction, the word is w = {firstParcel, secondParcel}. The C field is w[11:6], the B field is {w[14:12], w[26:24]}, and the long-immediate code is 62. In major group 4, the sub-opcode is w[21:16] and the format is w[23:22]. A register form is format 0, or format 3 with w[5]=0. In a register form, 4 bytes are added when B or C equals 62. The move sub-opcode 10 and the jump sub-opcodes 32–35 test only C. Sub-opcode 40 and formats 1 and 2 never add bytes.
- R3: The 16-bit major opcode 14 adds 4 bytes when `firstParcel[4:3]` is not 3 and {firstParcel[2:0], firstParcel[7:5]} equals 62.
- R4: Major 0 is a direct jump with delay slot w[5]. When w[16]=1 the offset is sext({w[3:0], w[15:6], w[26:17], 0}) over 25 bits; when w[16]=0 it is sext({w[15:6], w[26:17], 0}) over 21 bits.
- R5: In major 1, w[16]=1 gives a direct call: w[17]=1 selects the 25-bit offset of R4 with bits 1:0 cleared, and w[17]=0 selects the 21-bit offset. w[16]=0 gives a direct jump with offset sext({w[15], w[23:17], 0}) over 9 bits, bits 1:0 cleared. In both cases the delay slot is w[5].
- R6: Every PC-relative target is the offset plus the PC with bits 1:0 cleared.
- R7: Sub-opcodes 32–35 of group 4 are jumps; odd values have a delay slot and 34–35 are calls. The register form works as follows. If C is 62, the flow is direct with target `immWord`. Otherwise the flow is indirect, `tgtReg` = C and the target is 0. Format 2 is direct to the absolute target sext({w[5:0], w[11:6]}) over 12 bits. The remaining forms are direct to the absolute target C zero-extended.
- R8: Sub-opcode 40 with format 3 is a direct jump to (C << 1) plus the aligned PC. With any other format it is not a branch.
- R9: 16-bit major 29 branches by sext({firstParcel[6:0], 0}) over 8 bits. Major 30 branches by sext({firstParcel[5:0], 0}) over 7 bits when firstParcel[10:9]=3, and otherwise by sext({firstParcel[8:0], 0}) over 10 bits. Major 31 calls with offset sext({firstParcel[10:0], 00}) over 13 bits. None of these has a delay slot.
- R10: `flowKind` encodes 0 = direct jump, 1 = direct call, 2 = indirect jump, 3 = indirect call. When `isBranch` is 0, `flowKind`, `delaySlot`, `target` and `tgtReg` are all 0. `tgtReg` is 0 unless the flow is indirect.
- R11: With `OUT_REG`=1 (the default), outputs follow the inputs one clock later. A synchronous reset sets `lenBytes` to 2 and every other output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| firstParcel | input | 16 | Parcel at the fetch address |
| secondParcel | input | 16 | Following parcel |
| immWord | input | ADDR_W | Word after the instruction (possible long immediate) |
| pc | input | ADDR_W | Address of the instruction |
| lenBytes | output | 4 | Instruction length: 2, 4, 6 or 8 |
| isBranch | output | 1 | Instruction may redirect the PC |
| flowKind | output | 2 | Flow class per R10 |
| delaySlot | output | 1 | Next instruction executes before the transfer |
| target | output | ADDR_W | Direct target address |
| tgtReg | output | 6 | Register index of an indirect target |

## Verification
Directed parcels cover each major and sub-opcode class, in the following ways:
- Offsets with the sign bit set show whether sign extension and the aligned-PC base are right.
- The long-immediate code is placed first in B and then in C, with move, generic and jump sub-opcodes. This shows which operations test which field.
- The format field is swept, with and without bit 5, to separate register, 6-bit and 12-bit jump operands.
- Opcodes 10 and 11 sit either side of the 16/32-bit boundary.

Several thousand random parcels, biased towards these opcodes and towards the code 62, are then compared every cycle against a behavioural model.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  localparam int unsigned LIMM_CODE   = 62;
  localparam int unsigned LONG_LIMIT  = 11;
  localparam int unsigned MAJ_BRANCH  = 0;
  localparam int unsigned MAJ_BLINK   = 1;
  localparam int unsigned MAJ_GENERAL = 4;
  localparam int unsigned MAJ_SHLIMM  = 14;
  localparam int unsigned MAJ_SBR8    = 29;
  localparam int unsigned MAJ_SBR10   = 30;
  localparam int unsigned MAJ_SCALL   = 31;
  localparam int unsigned SUB_MOVE    = 10;
  localparam int unsigned SUB_LOOP    = 40;

  typedef enum logic [1:0] {
    FLOW_DJMP  = 2'd0,
    FLOW_DCALL = 2'd1,
    FLOW_IJMP  = 2'd2,
    FLOW_ICALL = 2'd3
  } flow_e;

  typedef enum logic [3:0] {
    TS_NONE, TS_B25, TS_B21, TS_C25, TS_CMP9, TS_LIMM, TS_U6,
    TS_S12, TS_LOOP, TS_S8, TS_S7, TS_S10, TS_S13
  } tsel_e;

  typedef struct packed {
    logic  long32;
    logic  addImm;
    logic  branch;
    flow_e flow;
    logic  delay;
    tsel_e tsel;
  } strobe_t;

endpackage

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   instWord,
  output strobe_t       strobe,
  output logic [5:0]    regIdx
);

  logic [4:0]  major;
  logic [5:0]  subop;
  logic [1:0]  fmt;
  logic [5:0]  cFld;
  logic [5:0]  bFld;
  logic [5:0]  hFld;
  logic        regForm;
  logic        cLimm;
  logic        bLimm;
  logic        unusedBits;

  assign major      = instWord[31:27];
  assign subop      = instWord[21:16];
  assign fmt        = instWord[23:22];
  assign cFld       = instWord[11:6];
  assign bFld       = {instWord[14:12], instWord[26:24]};
  assign hFld       = {instWord[18:16], instWord[23:21]};
  assign regForm    = (fmt == 2'd0) || (fmt == 2'd3 && !instWord[5]);
  assign cLimm      = (cFld == 6'(LIMM_CODE));
  assign bLimm      = (bFld == 6'(LIMM_CODE));
  assign unusedBits = ^{instWord[15], instWord[4:0]};

  always_comb begin
    strobe        = '0;
    strobe.flow   = FLOW_DJMP;
    strobe.tsel   = TS_NONE;
    regIdx        = '0;
    if (major < 5'(LONG_LIMIT)) begin
      strobe.long32 = 1'b1;
      case (major)
        5'(MAJ_BRANCH): begin
          strobe.branch = 1'b1;
          strobe.delay  = instWord[5];
          strobe.tsel   = instWord[16] ? TS_B25 : TS_B21;
        end
        5'(MAJ_BLINK): begin
          strobe.branch = 1'b1;
          strobe.delay  = instWord[5];
          if (instWord[16]) begin
            strobe.flow = FLOW_DCALL;
            strobe.tsel = instWord[17] ? TS_C25 : TS_B21;
          end else begin
            strobe.tsel = TS_CMP9;
          end
        end
        5'(MAJ_GENERAL): begin
          if (subop >= 6'd32 && subop <= 6'd35) begin
            strobe.branch = 1'b1;
            strobe.delay  = subop[0];
            if (regForm && !cLimm) begin
              strobe.flow = subop[1] ? FLOW_ICALL : FLOW_IJMP;
              regIdx      = cFld;
            end else begin
              strobe.flow = subop[1] ? FLOW_DCALL : FLOW_DJMP;
              if (regForm) begin
                strobe.addImm = 1'b1;
                strobe.tsel   = TS_LIMM;
              end else if (fmt == 2'd2) begin
                strobe.tsel = TS_S12;
              end else begin
                strobe.tsel = TS_U6;
              end
            end
          end else if (subop == 6'(SUB_LOOP)) begin
            if (fmt == 2'd3) begin
              strobe.branch = 1'b1;
              strobe.tsel   = TS_LOOP;
            end
          end else if (subop == 6'(SUB_MOVE)) begin
            strobe.addImm = regForm && cLimm;
          end else begin
            strobe.addImm = regForm && (cLimm || bLimm);
          end
        end
        default: ;
      endcase
    end else begin
      case (major)
        5'(MAJ_SHLIMM): strobe.addImm = (instWord[20:19] != 2'd3) && (hFld == 6'(LIMM_CODE));
        5'(MAJ_SBR8): begin
          strobe.branch = 1'b1;
          strobe.tsel   = TS_S8;
        end
        5'(MAJ_SBR10): begin
          strobe.branch = 1'b1;
          strobe.tsel   = (instWord[26:25] == 2'd3) ? TS_S7 : TS_S10;
        end
        5'(MAJ_SCALL): begin
          strobe.branch = 1'b1;
          strobe.flow   = FLOW_DCALL;
          strobe.tsel   = TS_S13;
        end
        default: ;
      endcase
    end
  end

  // R9: no 16-bit form ever carries a delay slot
  p_short_no_delay_r9: assert property (@(posedge clk) disable iff (rst)
    (instWord[31:27] >= 5'(LONG_LIMIT)) |-> !strobe.delay);

  // R7: an indirect flow never picks a computed target nor a long immediate
  p_indirect_no_target_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.branch && strobe.flow[1]) |-> (strobe.tsel == TS_NONE && !strobe.addImm));

endmodule

// File: rtl/vlen_datapath.sv
module vlen_datapath
  import vlen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       instWord,
  input  logic [ADDR_W-1:0] immWord,
  input  logic [ADDR_W-1:0] pc,
  input  strobe_t           strobe,
  output logic [3:0]        lenBytes,
  output logic [ADDR_W-1:0] target
);

  localparam int unsigned LEN_W = 4;

  logic [ADDR_W-1:0] alignedPc;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] absTarget;
  logic              pcRel;
  logic              unusedBits;

  assign alignedPc  = {pc[ADDR_W-1:2], 2'b00};
  assign unusedBits = ^{instWord[31:27], pc[1:0]};

  always_comb begin
    offset    = '0;
    absTarget = '0;
    pcRel     = 1'b1;
    case (strobe.tsel)
      TS_B25:  offset = ADDR_W'($signed({instWord[3:0], instWord[15:6], instWord[26:17], 1'b0}));
      TS_B21:  offset = ADDR_W'($signed({instWord[15:6], instWord[26:17], 1'b0}));
      TS_C25:  offset = ADDR_W'($signed({instWord[3:0], instWord[15:6], instWord[26:18], 2'b00}));
      TS_CMP9: offset = ADDR_W'($signed({instWord[15], instWord[23:18], 2'b00}));
      TS_LOOP: offset = ADDR_W'({instWord[11:6], 1'b0});
      TS_S8:   offset = ADDR_W'($signed({instWord[22:16], 1'b0}));
      TS_S7:   offset = ADDR_W'($signed({instWord[21:16], 1'b0}));
      TS_S10:  offset = ADDR_W'($signed({instWord[24:16], 1'b0}));
      TS_S13:  offset = ADDR_W'($signed({instWord[26:16], 2'b00}));
      TS_LIMM: begin
        pcRel     = 1'b0;
        absTarget = immWord;
      end
      TS_U6: begin
        pcRel     = 1'b0;
        absTarget = ADDR_W'(instWord[11:6]);
      end
      TS_S12: begin
        pcRel     = 1'b0;
        absTarget = ADDR_W'($signed({instWord[5:0], instWord[11:6]}));
      end
      default: pcRel = 1'b0;
    endcase
  end

  assign target   = pcRel ? (alignedPc + offset) : absTarget;
  assign lenBytes = (strobe.long32 ? LEN_W'(4) : LEN_W'(2)) + (strobe.addImm ? LEN_W'(4) : LEN_W'(0));

  // R5: call offsets and compare-branch offsets are word aligned
  p_aligned_word_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.tsel == TS_C25 || strobe.tsel == TS_CMP9 || strobe.tsel == TS_S13) |-> (target[1:0] == 2'b00));

  // R6: every relative target keeps the aligned base low bits clear when offset is even by four
  p_loop_even_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.tsel == TS_LOOP) |-> (target[0] == 1'b0));

endmodule

// File: rtl/vlen_decode.sv
module vlen_decode
  import vlen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       firstParcel,
  input  logic [15:0]       secondParcel,
  input  logic [ADDR_W-1:0] immWord,
  input  logic [ADDR_W-1:0] pc,
  output logic [3:0]        lenBytes,
  output logic              isBranch,
  output logic [1:0]        flowKind,
  output logic              delaySlot,
  output logic [ADDR_W-1:0] target,
  output logic [5:0]        tgtReg
);

  logic [31:0]       instWord;
  strobe_t           strobe;
  logic [5:0]        regIdx;
  logic [3:0]        lenComb;
  logic [ADDR_W-1:0] tgtComb;

  assign instWord = {firstParcel, secondParcel};

  vlen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instWord (instWord),
    .strobe   (strobe),
    .regIdx   (regIdx)
  );

  vlen_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .instWord (instWord),
    .immWord  (immWord),
    .pc       (pc),
    .strobe   (strobe),
    .lenBytes (lenComb),
    .target   (tgtComb)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          lenBytes  <= 4'd2;
          isBranch  <= 1'b0;
          flowKind  <= 2'd0;
          delaySlot <= 1'b0;
          target    <= '0;
          tgtReg    <= '0;
        end else begin
          lenBytes  <= lenComb;
          isBranch  <= strobe.branch;
          flowKind  <= strobe.flow;
          delaySlot <= strobe.delay;
          target    <= tgtComb;
          tgtReg    <= regIdx;
        end
      end

      // R11: registered length follows the decoded length by one cycle
      p_reg_latency_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lenBytes == $past(lenComb)));
    end else begin : g_comb
      assign lenBytes  = lenComb;
      assign isBranch  = strobe.branch;
      assign flowKind  = strobe.flow;
      assign delaySlot = strobe.delay;
      assign target    = tgtComb;
      assign tgtReg    = regIdx;
    end
  endgenerate

  // R10: a non-branch reports a quiet flow, delay and target
  p_nobranch_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !isBranch |-> (flowKind == 2'd0 && !delaySlot && target == '0 && tgtReg == '0));

  // R1: length is always one of the legal values
  p_len_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (lenBytes == 4'd2 || lenBytes == 4'd4 || lenBytes == 4'd6 || lenBytes == 4'd8));

endmodule

// File: tb/vlen_decode_tb.sv
module vlen_decode_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] firstParcel = '0;
  logic [15:0] secondParcel = '0;
  logic [31:0] immWord = '0;
  logic [31:0] pc = '0;
  logic [3:0]  lenBytes;
  logic        isBranch;
  logic [1:0]  flowKind;
  logic        delaySlot;
  logic [31:0] target;
  logic [5:0]  tgtReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  vlen_decode u_dut (
    .clk(clk), .rst(rst), .firstParcel(firstParcel), .secondParcel(secondParcel),
    .immWord(immWord), .pc(pc), .lenBytes(lenBytes), .isBranch(isBranch),
    .flowKind(flowKind), .delaySlot(delaySlot), .target(target), .tgtReg(tgtReg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sx(input logic [31:0] v, input int n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return v[n-1] ? (v | ~mask) : (v & mask);
  endfunction

  task automatic model(input logic [15:0] p0, input logic [15:0] p1, input logic [31:0] imm,
                       input logic [31:0] ipc, output int len, output bit br, output int fl,
                       output bit dl, output logic [31:0] tg, output int rg, output string tag);
    logic [31:0] w, ap, off;
    int maj, sub, f, c, b;
    bit rf, call;
    w = {p0, p1}; maj = int'(p0[15:11]); ap = ipc & ~32'd3;
    len = (maj < 11) ? 4 : 2; br = 0; fl = 0; dl = 0; tg = 0; rg = 0; tag = "R1";
    case (maj)
      0: begin
        tag = "R4"; br = 1; dl = w[5];
        off = w[16] ? sx(32'({w[3:0], w[15:6], w[26:17], 1'b0}), 25)
                    : sx(32'({w[15:6], w[26:17], 1'b0}), 21);
        tg = ap + off;
      end
      1: begin
        tag = "R5"; br = 1; dl = w[5];
        if (w[16]) begin
          fl = 1;
          off = w[17] ? (sx(32'({w[3:0], w[15:6], w[26:17], 1'b0}), 25) & ~32'd3)
                      : sx(32'({w[15:6], w[26:17], 1'b0}), 21);
        end else begin
          off = sx(32'({w[15], w[23:17], 1'b0}), 9) & ~32'd3;
        end
        tg = ap + off;
      end
      4: begin
        sub = int'(w[21:16]); f = int'(w[23:22]); c = int'(w[11:6]); b = int'({w[14:12], w[26:24]});
        rf = (f == 0) || (f == 3 && !w[5]);
        if (sub >= 32 && sub <= 35) begin
          tag = "R7"; br = 1; dl = sub[0]; call = (sub >= 34);
          if (rf && c == 62) begin len += 4; tg = imm; fl = call ? 1 : 0; end
          else if (rf) begin fl = call ? 3 : 2; rg = c; end
          else if (f == 2) begin tg = sx(32'({w[5:0], w[11:6]}), 12); fl = call ? 1 : 0; end
          else begin tg = 32'(c); fl = call ? 1 : 0; end
        end else if (sub == 40) begin
          tag = "R8";
          if (f == 3) begin br = 1; tg = ap + 32'(c * 2); end
        end else if (sub == 10) begin
          tag = "R2"; if (rf && c == 62) len += 4;
        end else begin
          tag = "R2"; if (rf && (c == 62 || b == 62)) len += 4;
        end
      end
      14: begin
        tag = "R3"; if (p0[4:3] != 2'd3 && {p0[2:0], p0[7:5]} == 6'd62) len += 4;
      end
      29: begin tag = "R9"; br = 1; tg = ap + sx(32'({p0[6:0], 1'b0}), 8); end
      30: begin
        tag = "R9"; br = 1;
        tg = ap + ((p0[10:9] == 2'd3) ? sx(32'({p0[5:0], 1'b0}), 7) : sx(32'({p0[8:0], 1'b0}), 10));
      end
      31: begin tag = "R9"; br = 1; fl = 1; tg = ap + sx(32'({p0[10:0], 2'b00}), 13); end
      default: tag = "R10";
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] p0, input logic [15:0] p1, input logic [31:0] imm, input logic [31:0] ipc);
    int len, fl, rg;
    bit br, dl;
    logic [31:0] tg;
    string tag;
    model(p0, p1, imm, ipc, len, br, fl, dl, tg, rg, tag);
    firstParcel = p0; secondParcel = p1; immWord = imm; pc = ipc;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "len", 32'(lenBytes), 32'(len));
    chk(tag, "branch", 32'(isBranch), 32'(br));
    chk(br ? tag : "R10", "flow", 32'(flowKind), 32'(fl));
    chk(tag, "delay", 32'(delaySlot), 32'(dl));
    chk(br ? "R6" : "R10", "target", target, tg);
    chk(tag, "reg", 32'(tgtReg), 32'(rg));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", "rst len", 32'(lenBytes), 32'd2);
    chk("R11", "rst branch", 32'(isBranch), 32'd0);
    chk("R11", "rst target", target, 32'd0);
    rst = 1'b0;
    apply(16'h0001, 16'h002F, 32'h0, 32'h0000_1003);  // R4 s25 negative with delay
    apply(16'h07FE, 16'hFFC0, 32'h0, 32'h0000_1000);  // R4 s21
    apply(16'h0803, 16'h1234, 32'h0, 32'h0000_2002);  // R5 call s25
    apply(16'h0801, 16'hFFE0, 32'h0, 32'h0000_2000);  // R5 call s21
    apply(16'h08FE, 16'h8020, 32'h0, 32'h0000_3001);  // R5 compare-branch
    apply(16'h2020, 16'h0140, 32'h0, 32'h0000_4000);  // R7 indirect jump reg 5
    apply(16'h2023, 16'h0F80, 32'hDEAD_BEE0, 32'h0);  // R7 limm call delay, len 8
    apply(16'h20A2, 16'h0FFF, 32'h0, 32'h0);          // R7 s12 absolute
    apply(16'h20E1, 16'h0FA0, 32'h0, 32'h0);          // R7 u6 absolute
    apply(16'h20E2, 16'h01C0, 32'h0, 32'h0);          // R7 indirect call reg 7
    apply(16'h20E8, 16'h0FC0, 32'h0, 32'h0000_0102);  // R8 loop
    apply(16'h2028, 16'h0FC0, 32'h0, 32'h0000_0102);  // R8 loop not format 3
    apply(16'h260A, 16'h7000, 32'h0, 32'h0);          // R2 move ignores B
    apply(16'h2602, 16'h7000, 32'h0, 32'h0);          // R2 generic B limm
    apply(16'h2042, 16'h0F80, 32'h0, 32'h0);          // R2 format 1 no add
    apply(16'h20C2, 16'h0F80, 32'h0, 32'h0);          // R2 format 3 bit5 clear
    apply(16'h20C2, 16'h0FA0, 32'h0, 32'h0);          // R2 format 3 bit5 set
    apply(16'h70C7, 16'h0000, 32'h0, 32'h0);          // R3 short limm len 6
    apply(16'h70DF, 16'h0000, 32'h0, 32'h0);          // R3 ignored form
    apply(16'hE87F, 16'h0000, 32'h0, 32'h0000_0106);  // R9 s8
    apply(16'hF63F, 16'h0000, 32'h0, 32'h0000_0106);  // R9 s7
    apply(16'hF1FF, 16'h0000, 32'h0, 32'h0000_0106);  // R9 s10
    apply(16'hFFFF, 16'h0000, 32'h0, 32'h0000_0106);  // R9 s13 call
    apply(16'h1000, 16'hFFFF, 32'h0, 32'h0);          // R10 non-branch 32-bit
    apply(16'h6000, 16'hFFFF, 32'h0, 32'h0);          // R10 non-branch 16-bit
    apply(16'h5000, 16'h0000, 32'h0, 32'h0);          // R1 major 10 is long
    apply(16'h5800, 16'h0000, 32'h0, 32'h0);          // R1 major 11 is short
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] p0, p1;
      logic [4:0] majPick [11];
      int r;
      majPick = '{5'd0, 5'd1, 5'd4, 5'd4, 5'd4, 5'd2, 5'd14, 5'd29, 5'd30, 5'd31, 5'd12};
      p0 = 16'($urandom); p1 = 16'($urandom);
      p0[15:11] = majPick[$urandom_range(0, 10)];
      if (p0[15:11] == 5'd4) begin
        r = $urandom_range(0, 6);
        case (r)
          0, 1: p0[5:0] = 6'(32 + $urandom_range(0, 3));
          2: p0[5:0] = 6'd40;
          3: p0[5:0] = 6'd10;
          default: ;
        endcase
        if ($urandom_range(0, 2) == 0) p1[11:6] = 6'd62;
        if ($urandom_range(0, 2) == 0) begin p1[14:12] = 3'd7; p0[10:8] = 3'd6; end
      end
      if (p0[15:11] == 5'd14 && $urandom_range(0, 1) == 0) begin p0[2:0] = 3'd7; p0[7:5] = 3'd6; end
      apply(p0, p1, $urandom, $urandom);
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule